// File: doc/BRIEF.md
# Ethernet PHY Bring-up Sequencer

This block brings an external Ethernet PHY out of power-up from the MAC side of a chip. On a start pulse it asserts the active-low PHY reset. While reset is held, it drives the pins that the PHY samples as configuration straps to captured levels. It then releases reset, drops the strap drivers so those pins return to normal MII use, and waits out a settling interval. Only after that does it touch the management bus.

Discovery uses a built-in clause-22 management master. The master issues read frames to one identification register. In scan mode it starts at a preferred address and steps through all 32 addresses, wrapping. In fixed mode it re-reads a single address, which covers PHYs that answer only long after power-up. The first read that returns the expected identifier ends the sequence with a done flag and the responding address. If no read matches and the discovery budget has run out, a timeout flag is raised and the bus goes quiet. All intervals are cycle-count parameters.

Top module: `phy_bringup_seq`

## Requirements
- R1: After system reset, phy_rst_n is 0, strap_oe is 0, mdio_pull_low is 0, and done and timeout are 0.
- R2: When start is sampled while idle, done or failed, phy_rst_n is 0 for exactly RESET_CYCLES clocks, beginning with the cycle after the sampling edge. It is 1 from then on.
- R3: strap_oe is 1, and strap_o equals strap_val as sampled with start, exactly during the reset-hold cycles. strap_oe is 0 at all other times.
- R4: For SETTLE_CYCLES clocks after reset release, the block does not pull MDIO, and done and timeout stay 0.
- R5: mdc toggles every MDC_HALF clocks. mdio_pull_low changes only in the cycle in which mdc falls. MDIO is only ever pulled low or released.
- R6: Each read frame is 32 ones, start bits 0 then 1, opcode 1 then 0, the 5-bit PHY address MSB first, and register ID_REG MSB first. MDIO is released for 2 turnaround bits, then 16 data bits are sampled MSB first on rising mdc.
- R7: With cfg_scan_en=1, the first read goes to cfg_phy_addr. Each non-matching read is followed by a read to the next address modulo 32.
- R8: With cfg_scan_en=0, every read goes to cfg_phy_addr until one matches.
- R9: A read matches only when its data equals ID_VALUE. The block then sets done=1 and found_addr to that read's address, and holds both until the next accepted start.
- R10: If a read does not match and at least TIMEOUT_CYCLES clocks have passed since the first read began, timeout is set to 1 and no further frames are issued.
- R11: A start pulse while a sequence is running has no effect: reset stays released and the sequence runs on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| start | input | 1 | Begins a bring-up sequence when idle, done or failed |
| cfg_phy_addr | input | 5 | Preferred or fixed PHY address |
| cfg_scan_en | input | 1 | 1 = scan all addresses, 0 = poll cfg_phy_addr only |
| strap_val | input | STRAP_W | Levels to drive onto strap pins during reset |
| phy_rst_n | output | 1 | Active-low PHY reset |
| strap_o | output | STRAP_W | Strap pin drive values |
| strap_oe | output | 1 | Strap pin output enable |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Resolved level of the open-drain MDIO line |
| mdio_pull_low | output | 1 | 1 = pull MDIO low, 0 = release |
| done | output | 1 | PHY found |
| found_addr | output | 5 | Address that returned the identifier |
| timeout | output | 1 | Discovery gave up |

## Verification
The assertions take for granted that mdio_i is the wired-AND of this block and a responder that changes its drive only after a falling mdc. They also assume that start is a clean, synchronous level. The bench resolves the line exactly that way. Its responder updates only on falling mdc and releases the line at the end of the data phase. All inputs change one time unit after a rising clock, so every sampled value is settled. Configuration inputs are held steady for the length of each sequence.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET_HOLD,
    ST_SETTLE,
    ST_READ_ID,
    ST_CHECK,
    ST_NEXT_ADDR,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  localparam int PREAMBLE_BITS = 32;
  localparam int HDR_BITS      = PREAMBLE_BITS + 14;
  localparam int TA_BITS       = 2;
  localparam int DATA_BITS     = 16;
  localparam int FRAME_BITS    = HDR_BITS + TA_BITS + DATA_BITS;
  localparam int IDX_W         = $clog2(FRAME_BITS);

  // Driven portion of a clause-22 read, first bit on the wire in the MSB.
  function automatic logic [HDR_BITS-1:0] read_header(input logic [4:0] pa,
                                                      input logic [4:0] ra);
    return {{PREAMBLE_BITS{1'b1}}, 2'b01, 2'b10, pa, ra};
  endfunction

  // Address used after a non-matching read.
  function automatic logic [4:0] step_addr(input logic [4:0] a, input logic scan);
    return scan ? a + 5'd1 : a;
  endfunction

endpackage

// File: rtl/phy_mdc_gen.sv
module phy_mdc_gen #(
  parameter int HALF_PERIOD = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic mdc_rise,
  output logic mdc_fall
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc      = mdc_q;
  assign mdc_rise = tick & ~mdc_q;
  assign mdc_fall = tick & mdc_q;

  // R5: the clock pin moves only on a divider tick
  a_r5_mdc_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc_q) |-> $past(tick));

endmodule

// File: rtl/phy_mdio_reader.sv
module phy_mdio_reader
  import phy_bringup_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdc_rise,
  input  logic        mdc_fall,
  input  logic        req,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic        mdio_i,
  output logic        mdio_pull_low,
  output logic        busy,
  output logic        rd_done,
  output logic [15:0] rd_data
);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] DATA_FIRST = IDX_W'(HDR_BITS + TA_BITS);
  localparam logic [IDX_W-1:0] HDR_END    = IDX_W'(HDR_BITS);

  logic                busy_q;
  logic                on_q;
  logic [IDX_W-1:0]    idx_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic [15:0]         data_q;
  logic                done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      on_q   <= 1'b0;
      idx_q  <= '0;
      hdr_q  <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (req && !busy_q) begin
        busy_q <= 1'b1;
        on_q   <= 1'b0;
        idx_q  <= '0;
        hdr_q  <= read_header(phy_addr, reg_addr);
      end else if (busy_q && mdc_fall) begin
        if (!on_q) begin
          on_q  <= 1'b1;
          idx_q <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
          hdr_q <= {hdr_q[HDR_BITS-2:0], 1'b1};
        end
      end else if (on_q && mdc_rise) begin
        if (idx_q >= DATA_FIRST) data_q <= {data_q[14:0], mdio_i};
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          on_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign mdio_pull_low = on_q && (idx_q < HDR_END) && !hdr_q[HDR_BITS-1];
  assign busy          = busy_q;
  assign rd_done       = done_q;
  assign rd_data       = data_q;

  // R5: the line drive only changes together with a falling management clock
  a_r5_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_pull_low) |-> $past(mdc_fall));

  // R6: completion follows the sampling of the last data bit
  a_r6_done_at_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(mdc_rise) && !busy);

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_bringup_pkg::*;
#(
  parameter int          STRAP_W        = 4,
  parameter int          RESET_CYCLES   = 550000,
  parameter int          SETTLE_CYCLES  = 10000,
  parameter int          TIMEOUT_CYCLES = 10000000,
  parameter logic [15:0] ID_VALUE       = 16'h0022
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [4:0]         cfg_phy_addr,
  input  logic               cfg_scan_en,
  input  logic [STRAP_W-1:0] strap_val,
  input  logic               rd_busy,
  input  logic               rd_done,
  input  logic [15:0]        rd_data,
  output logic               rd_req,
  output logic [4:0]         rd_addr,
  output logic               phy_rst_n,
  output logic [STRAP_W-1:0] strap_o,
  output logic               strap_oe,
  output logic               done,
  output logic [4:0]         found_addr,
  output logic               timeout
);
  localparam int CNT_MAX = (RESET_CYCLES > SETTLE_CYCLES) ? RESET_CYCLES : SETTLE_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int TW      = $clog2(TIMEOUT_CYCLES + 1);

  seq_state_t         state_q;
  logic [CW-1:0]      tcnt_q;
  logic [TW-1:0]      wcnt_q;
  logic [4:0]         cur_addr_q;
  logic [4:0]         found_q;
  logic               scan_q;
  logic               issued_q;
  logic [15:0]        id_q;
  logic [STRAP_W-1:0] strap_q;

  logic hold_expired, settle_expired, timer_expired, id_match, accept_start, discovering;

  assign hold_expired   = (state_q == ST_RESET_HOLD) && (tcnt_q == CW'(RESET_CYCLES - 1));
  assign settle_expired = (state_q == ST_SETTLE) && (tcnt_q == CW'(SETTLE_CYCLES - 1));
  assign timer_expired  = (wcnt_q >= TW'(TIMEOUT_CYCLES));
  assign id_match       = (id_q == ID_VALUE);
  assign accept_start   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE) ||
                                    (state_q == ST_FAIL));
  assign discovering    = (state_q == ST_READ_ID) || (state_q == ST_CHECK) ||
                          (state_q == ST_NEXT_ADDR);
  assign rd_req         = (state_q == ST_READ_ID) && !issued_q && !rd_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tcnt_q     <= '0;
      wcnt_q     <= '0;
      cur_addr_q <= '0;
      found_q    <= '0;
      scan_q     <= 1'b0;
      issued_q   <= 1'b0;
      id_q       <= '0;
      strap_q    <= '0;
    end else begin
      if (discovering && !timer_expired) wcnt_q <= wcnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (accept_start) begin
            state_q    <= ST_RESET_HOLD;
            tcnt_q     <= '0;
            strap_q    <= strap_val;
            cur_addr_q <= cfg_phy_addr;
            scan_q     <= cfg_scan_en;
          end
        end
        ST_RESET_HOLD: begin
          if (hold_expired) begin
            state_q <= ST_SETTLE;
            tcnt_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_expired) begin
            state_q  <= ST_READ_ID;
            wcnt_q   <= '0;
            issued_q <= 1'b0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_READ_ID: begin
          if (rd_req) issued_q <= 1'b1;
          if (issued_q && rd_done) begin
            id_q    <= rd_data;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (id_match) begin
            found_q <= cur_addr_q;
            state_q <= ST_DONE;
          end else if (timer_expired) begin
            state_q <= ST_FAIL;
          end else begin
            state_q <= ST_NEXT_ADDR;
          end
        end
        ST_NEXT_ADDR: begin
          cur_addr_q <= step_addr(cur_addr_q, scan_q);
          issued_q   <= 1'b0;
          state_q    <= ST_READ_ID;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr    = cur_addr_q;
  assign phy_rst_n  = (state_q != ST_IDLE) && (state_q != ST_RESET_HOLD);
  assign strap_oe   = (state_q == ST_RESET_HOLD);
  assign strap_o    = strap_q;
  assign done       = (state_q == ST_DONE);
  assign timeout    = (state_q == ST_FAIL);
  assign found_addr = found_q;

  // R2: reset is released only when the hold count has run out
  a_r2_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n) |-> $past(hold_expired));

  // R3: straps are driven only while the PHY is in reset
  a_r3_strap_only_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    strap_oe |-> !phy_rst_n);

  // R4: a management read is requested only with reset released and straps off
  a_r4_read_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> phy_rst_n && !strap_oe && !done && !timeout);

  // R9: result and address hold until a new start
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(found_addr));

  // R10: failure only after the discovery budget is spent
  a_r10_fail_needs_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(timer_expired));

  // R10: the two results exclude each other
  a_r10_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  // R11: a start during discovery leaves reset released
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    discovering && start |=> phy_rst_n);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int          STRAP_W        = 4,
  parameter int          MDC_HALF       = 10,
  parameter int          RESET_CYCLES   = 550000,
  parameter int          SETTLE_CYCLES  = 10000,
  parameter int          TIMEOUT_CYCLES = 10000000,
  parameter logic [4:0]  ID_REG         = 5'd2,
  parameter logic [15:0] ID_VALUE       = 16'h0022
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [4:0]         cfg_phy_addr,
  input  logic               cfg_scan_en,
  input  logic [STRAP_W-1:0] strap_val,
  output logic               phy_rst_n,
  output logic [STRAP_W-1:0] strap_o,
  output logic               strap_oe,
  output logic               mdc,
  input  logic               mdio_i,
  output logic               mdio_pull_low,
  output logic               done,
  output logic [4:0]         found_addr,
  output logic               timeout
);
  logic        mdc_rise, mdc_fall;
  logic        rd_req, rd_busy, rd_done;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data;

  phy_mdc_gen #(.HALF_PERIOD(MDC_HALF)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall)
  );

  phy_mdio_reader u_reader (
    .clk           (clk),
    .rst_n         (rst_n),
    .mdc_rise      (mdc_rise),
    .mdc_fall      (mdc_fall),
    .req           (rd_req),
    .phy_addr      (rd_addr),
    .reg_addr      (ID_REG),
    .mdio_i        (mdio_i),
    .mdio_pull_low (mdio_pull_low),
    .busy          (rd_busy),
    .rd_done       (rd_done),
    .rd_data       (rd_data)
  );

  phy_seq_ctrl #(
    .STRAP_W        (STRAP_W),
    .RESET_CYCLES   (RESET_CYCLES),
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .ID_VALUE       (ID_VALUE)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_phy_addr (cfg_phy_addr),
    .cfg_scan_en  (cfg_scan_en),
    .strap_val    (strap_val),
    .rd_busy      (rd_busy),
    .rd_done      (rd_done),
    .rd_data      (rd_data),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .phy_rst_n    (phy_rst_n),
    .strap_o      (strap_o),
    .strap_oe     (strap_oe),
    .done         (done),
    .found_addr   (found_addr),
    .timeout      (timeout)
  );

endmodule

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW  = 4;
  localparam int H   = 2;
  localparam int RC  = 40;
  localparam int SC  = 20;
  localparam int TO  = 3000;
  localparam logic [4:0]  IDR = 5'd2;
  localparam logic [15:0] IDV = 16'h0022;
  localparam int FRAME_CYC = (64 + 2) * 2 * H + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] cfg_addr = 5'd0;
  logic cfg_scan = 1'b0;
  logic [SW-1:0] strap_val = '0;
  logic phy_rst_n, strap_oe, mdc, dut_pull, done, timeout;
  logic [SW-1:0] strap_o;
  logic [4:0] found_addr;
  logic phy_drv = 1'b0;
  wire mdio_line = !(dut_pull || phy_drv);

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_bringup_seq #(
    .STRAP_W(SW), .MDC_HALF(H), .RESET_CYCLES(RC), .SETTLE_CYCLES(SC),
    .TIMEOUT_CYCLES(TO), .ID_REG(IDR), .ID_VALUE(IDV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_phy_addr(cfg_addr),
    .cfg_scan_en(cfg_scan), .strap_val(strap_val), .phy_rst_n(phy_rst_n),
    .strap_o(strap_o), .strap_oe(strap_oe), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_pull_low(dut_pull), .done(done), .found_addr(found_addr), .timeout(timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural PHY responder ----------------
  int rsp_st = 0, hunt_ones = 0, rsp_cnt = 0, fcnt = 0;
  logic [11:0] rsp_sh = '0;
  logic [15:0] rsp_word = '0;
  bit rsp_on = 0;
  int frames_q[$];
  int hidden_addr = 0, decoy_addr = 0, ready_after = 0, hidden_reads = 0;
  bit hidden_en = 0, decoy_en = 0;

  always @(posedge mdc) begin
    case (rsp_st)
      0: if (mdio_line) hunt_ones++;
         else begin
           if (hunt_ones >= 32) rsp_st = 1;
           hunt_ones = 0;
         end
      1: if (mdio_line) begin rsp_st = 2; rsp_cnt = 0; rsp_sh = '0; end
         else rsp_st = 0;
      2: begin
        rsp_sh = {rsp_sh[10:0], mdio_line};
        rsp_cnt++;
        if (rsp_cnt == 12) begin
          check(rsp_sh[11:10] == 2'b10, "R6 opcode", int'(rsp_sh[11:10]), 2);
          check(rsp_sh[4:0] == IDR, "R6 register", int'(rsp_sh[4:0]), int'(IDR));
          frames_q.push_back(int'(rsp_sh[9:5]));
          rsp_on = 0;
          if (hidden_en && int'(rsp_sh[9:5]) == hidden_addr) begin
            hidden_reads++;
            if (hidden_reads > ready_after) begin rsp_on = 1; rsp_word = IDV; end
          end else if (decoy_en && int'(rsp_sh[9:5]) == decoy_addr) begin
            rsp_on = 1; rsp_word = 16'h1234;
          end
          rsp_st = 3;
        end
      end
      default: if (fcnt >= 19) begin rsp_st = 0; hunt_ones = 0; end
    endcase
  end

  always @(negedge mdc) begin
    if (rsp_st != 3) fcnt = 0;
    else begin
      fcnt++;
      if (fcnt >= 3 && fcnt <= 18) phy_drv = rsp_on && !rsp_word[18 - fcnt];
      else phy_drv = 1'b0;
    end
  end

  // ---------------- per-clock reference model ----------------
  bit started = 0, busy_m = 0, acc = 0;
  int n = 0, end_n = 0, since_tog = 0;
  bit seen_tog = 0;
  logic mdc_prev = 1'b0, pull_prev = 1'b0;
  logic [SW-1:0] cap = '0, cap_next = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc) begin busy_m = 1; started = 1; n = 0; cap = cap_next; end
      if (busy_m) n++;
      if (!started) begin
        check(!phy_rst_n && !strap_oe && !dut_pull, "R1 idle", int'(phy_rst_n), 0);
      end else if (busy_m) begin
        if (n <= RC) begin
          check(phy_rst_n == 1'b0, "R2 hold", int'(phy_rst_n), 0);
          check(strap_oe && strap_o == cap, "R3 drive", int'(strap_o), int'(cap));
          check(!dut_pull, "R4 no mdio in reset", int'(dut_pull), 0);
        end else if (n <= RC + SC) begin
          check(phy_rst_n == 1'b1, "R2 release", int'(phy_rst_n), 1);
          check(strap_oe == 1'b0, "R3 straps off", int'(strap_oe), 0);
          check(!dut_pull && !done && !timeout, "R4 settle quiet", int'(dut_pull), 0);
        end else begin
          check(phy_rst_n && !strap_oe, "R11 reset stays released", int'(phy_rst_n), 1);
          if (done || timeout) begin busy_m = 0; end_n = n; end
        end
      end else begin
        check(phy_rst_n && !strap_oe, "R2 released after run", int'(phy_rst_n), 1);
      end
      since_tog++;
      if (mdc != mdc_prev) begin
        if (seen_tog) check(since_tog == H, "R5 mdc half period", since_tog, H);
        seen_tog = 1;
        since_tog = 0;
      end
      if (dut_pull != pull_prev)
        check(mdc_prev == 1'b1 && mdc == 1'b0, "R5 drive on falling mdc", int'(mdc), 0);
      mdc_prev = mdc;
      pull_prev = dut_pull;
      acc = start && !busy_m;
      cap_next = strap_val;
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_result(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done || timeout) return;
    end
    check(0, "R9/R10 sequence end", 0, 1);
  endtask

  task automatic setup(input int pref, input bit scan, input logic [SW-1:0] sv);
    @(posedge clk); #1;
    cfg_addr = 5'(pref); cfg_scan = scan; strap_val = sv;
    frames_q.delete();
    hidden_reads = 0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!phy_rst_n, "R1 reset held", int'(phy_rst_n), 0);
    check(!strap_oe && !dut_pull, "R1 pins idle", int'(strap_oe), 0);
    check(!done && !timeout, "R1 flags clear", int'(done), 0);

    // Scan with wrap, decoy with wrong identifier at 31, PHY at 3
    hidden_en = 1; hidden_addr = 3; ready_after = 0;
    decoy_en = 1; decoy_addr = 31;
    setup(30, 1'b1, 4'b1010);
    pulse_start();
    wait (frames_q.size() >= 2);
    pulse_start();  // R11: ignored mid-run
    wait_result(20000);
    check(done == 1'b1 && !timeout, "R9 done after scan", int'(done), 1);
    check(found_addr == 5'd3, "R9 found address", int'(found_addr), 3);
    check(frames_q.size() == 6, "R7 read count with decoy", frames_q.size(), 6);
    foreach (frames_q[i])
      check(frames_q[i] == (30 + i) % 32, "R7 scan order", frames_q[i], (30 + i) % 32);
    repeat (500) @(negedge clk);
    check(done && found_addr == 5'd3, "R9 result held", int'(found_addr), 3);
    check(frames_q.size() == 6, "R9 bus quiet after done", frames_q.size(), 6);

    // Fixed address, PHY answers from its fourth read
    decoy_en = 0;
    hidden_addr = 5; ready_after = 3;
    setup(5, 1'b0, 4'b0101);
    pulse_start();
    @(negedge clk);
    check(!done, "R9 done cleared by start", int'(done), 0);
    wait_result(20000);
    check(done && found_addr == 5'd5, "R8 found fixed address", int'(found_addr), 5);
    check(frames_q.size() == 4, "R8 re-read count", frames_q.size(), 4);
    foreach (frames_q[i]) check(frames_q[i] == 5, "R8 same address", frames_q[i], 5);

    // Nobody answers: budget runs out
    hidden_en = 0;
    setup(10, 1'b1, 4'b1111);
    pulse_start();
    wait_result(20000);
    @(negedge clk);
    check(timeout && !done, "R10 timeout flag", int'(timeout), 1);
    check(end_n - (RC + SC + 1) > TO, "R10 budget honoured", end_n - (RC + SC + 1), TO + 1);
    check(end_n - (RC + SC + 1) <= TO + 2 * FRAME_CYC, "R10 stops promptly",
          end_n - (RC + SC + 1), TO + 2 * FRAME_CYC);
    check(frames_q.size() >= 2, "R7 several reads before timeout", frames_q.size(), 2);
    foreach (frames_q[i])
      check(frames_q[i] == (10 + i) % 32, "R7 order before timeout", frames_q[i], (10 + i) % 32);
    begin
      int sz;
      sz = frames_q.size();
      repeat (1500) @(negedge clk);
      check(frames_q.size() == sz, "R10 no reads after timeout", frames_q.size(), sz);
      check(timeout == 1'b1, "R10 timeout held", int'(timeout), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule